// File: doc/BRIEF.md
# Configurable LUT Logic Cell

This block is a soft model of one programmable logic cell. Two 5-bit input buses address four 16-entry look-up tables. Each table drives one storage element, and the four table outputs, or the stored values, appear on a 5-bit output bus. The fifth output bit combines two table outputs through a selectable gate. A 4-bit direct-data bus lets each storage element skip its table. The same bus also feeds a shift chain that joins the four elements into a 4-bit shift register.

A static configuration word sets how the cell behaves. It holds the table contents, the input source of each storage element, and whether each element is an edge-triggered flip-flop or a level-sensitive latch. It also sets whether each output is registered or combinational, the value loaded on set/reset, whether local set/reset beats clock enable, and the gate that forms the fifth output. The word is written through a parallel port while a write-enable input is high. A global set/reset loads every storage element asynchronously.

Top module: `lut_cell`

## Requirements
- R1: While `rst_n` is low and after its release, the configuration word is all zeros until written. The output bus then reads 5'b10000.
- R2: `cfg_data` is captured on a rising clock edge only while `cfg_we` is high. Otherwise the held word and the outputs do not change. Word layout, MSB first: four 16-bit tables (table 3 in bits 86:71 down to table 0 in bits 38:23), four 2-bit source codes (element 3 in bits 22:21 down to element 0 in 16:15), latch flags 14:11, registered-output flags 10:7, set/reset values 6:3, set/reset-first flag bit 2, fifth-output code 1:0.
- R3: Table 3 is indexed by `a_in[4:1]`, table 2 by `a_in[3:0]`, table 1 by `b_in[4:1]` and table 0 by `b_in[3:0]`. Where output k's registered flag is 0, `y_out[k]` is table k's entry at that index, with no clock involved.
- R4: `y_out[4]` combines table outputs f3 and f0 by code: 0 gives NAND, 1 gives XOR, 2 gives `a_in[4] ? f3 : f0`, and 3 gives XNOR.
- R5: Source code 0 feeds an element from its table, 1 from `wd_in[k]`, and 2 from element k-1, with element 0 taking `wd_in[0]`. A flip-flop loads on a rising edge while `clk_en` is high. A registered flag of 1 puts element k on `y_out[k]`. The fifth output keeps decoding the inputs while the chain shifts.
- R6: With `clk_en` low and no set/reset that takes priority, a flip-flop keeps its value across clock edges.
- R7: With the set/reset-first flag at 1, `lsr` loads the set/reset value whatever `clk_en` is. With the flag at 0, `lsr` acts only on an edge where `clk_en` is high.
- R8: `gsr` high loads each element's set/reset value at once, without waiting for a clock edge. It keeps that value across edges, whatever the other controls do.
- R9: An element in latch mode follows its input while `clk` is high and `clk_en` is high. It holds its value while `clk` is low or `clk_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock; also the latch gate |
| rst_n | input | 1 | Asynchronous active-low reset of the configuration word |
| cfg_we | input | 1 | Configuration write enable |
| cfg_data | input | 87 | Configuration word |
| a_in | input | 5 | Input bus A |
| b_in | input | 5 | Input bus B |
| wd_in | input | 4 | Direct storage-element data |
| clk_en | input | 1 | Clock enable for the storage elements |
| lsr | input | 1 | Local synchronous set/reset |
| gsr | input | 1 | Global asynchronous set/reset |
| y_out | output | 5 | Cell outputs |

## Verification
The assertions assume that the configuration word is not rewritten while `gsr` is high. They also assume that a `gsr` pulse stays high across at least one rising clock edge, so that hold and priority checks are switched off whenever the elements may have been forced between edges. The stimulus writes the configuration only with `clk_en` and `gsr` low. It raises `gsr` through a task that keeps it high over one full edge. Inputs change at least one time unit after a rising edge, and outputs are sampled a time unit after that.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int NREG   = 4;
  localparam int LUT_AW = 4;
  localparam int LUT_D  = 1 << LUT_AW;
  localparam int BUS_W  = NREG + 1;

  typedef enum logic [1:0] {
    SRC_LUT   = 2'd0,
    SRC_WD    = 2'd1,
    SRC_SHIFT = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    F5_NAND = 2'd0,
    F5_XOR  = 2'd1,
    F5_MUX  = 2'd2,
    F5_XNOR = 2'd3
  } f5_e;

  typedef struct packed {
    logic [NREG-1:0][LUT_D-1:0] lut_tbl;
    logic [NREG-1:0][1:0]       reg_src;
    logic [NREG-1:0]            is_latch;
    logic [NREG-1:0]            out_reg;
    logic [NREG-1:0]            sr_val;
    logic                       sr_first;
    f5_e                        f5_op;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/lcell_rst_sync.sv
module lcell_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lcell_lut.sv
module lcell_lut
  import lcell_pkg::*;
(
  input  logic [NREG-1:0][LUT_D-1:0] tbl,
  input  logic [BUS_W-1:0]           a_in,
  input  logic [BUS_W-1:0]           b_in,
  input  f5_e                        f5_op,
  output logic [NREG-1:0]            f,
  output logic                       f5
);
  for (genvar k = 0; k < NREG; k++) begin : g_tbl
    localparam int OFS   = k % 2;
    localparam bit USE_A = (k >= NREG / 2);
    logic [LUT_AW-1:0] idx;
    if (USE_A) begin : g_a
      assign idx = a_in[OFS +: LUT_AW];
    end else begin : g_b
      assign idx = b_in[OFS +: LUT_AW];
    end
    assign f[k] = tbl[k][idx];
  end

  always_comb begin
    unique case (f5_op)
      F5_NAND: f5 = ~(f[NREG-1] & f[0]);
      F5_XOR:  f5 = f[NREG-1] ^ f[0];
      F5_MUX:  f5 = a_in[BUS_W-1] ? f[NREG-1] : f[0];
      default: f5 = ~(f[NREG-1] ^ f[0]);
    endcase
  end
endmodule

// File: rtl/lcell_store.sv
module lcell_store
  import lcell_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gsr,
  input  logic       ce,
  input  logic       lsr,
  input  logic       sr_first,
  input  logic       sr_val,
  input  logic       is_latch,
  input  logic [1:0] src,
  input  logic       lut_bit,
  input  logic       wd_bit,
  input  logic       chain_bit,
  output logic       q
);
  logic d;
  logic sr_hit;
  logic ff_next;
  logic q_ff;
  logic q_lat;
  logic lat_open;
  logic lat_d;

  always_comb begin
    unique case (src)
      SRC_WD:    d = wd_bit;
      SRC_SHIFT: d = chain_bit;
      default:   d = lut_bit;
    endcase
  end

  assign sr_hit = lsr & (sr_first | ce);

  always_comb begin
    if (sr_hit)  ff_next = sr_val;
    else if (ce) ff_next = d;
    else         ff_next = q_ff;
  end

  always_ff @(posedge clk or posedge gsr) begin
    if (gsr) q_ff <= sr_val;
    else     q_ff <= ff_next;
  end

  assign lat_open = ce | (lsr & sr_first);
  assign lat_d    = sr_hit ? sr_val : d;

  always_latch begin
    if (gsr)                  q_lat = sr_val;
    else if (clk && lat_open) q_lat = lat_d;
  end

  assign q = is_latch ? q_lat : q_ff;

  assert_ce_hold_R6: assert property (@(posedge clk) disable iff (!rst_n || gsr)
    (!ce && !(lsr && sr_first)) |=> q_ff == $past(q_ff));

  assert_sr_first_R7: assert property (@(posedge clk) disable iff (!rst_n || gsr)
    (lsr && sr_first) |=> q_ff == $past(sr_val));

  assert_gsr_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gsr && $past(gsr) && $stable(sr_val)) |-> q == sr_val);
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lcell_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic [BUS_W-1:0] a_in,
  input  logic [BUS_W-1:0] b_in,
  input  logic [NREG-1:0]  wd_in,
  input  logic             clk_en,
  input  logic             lsr,
  input  logic             gsr,
  output logic [BUS_W-1:0] y_out
);
  logic            rst_sync_n;
  cfg_t            cfg_q;
  cfg_t            cfg_d;
  logic [NREG-1:0] f;
  logic            f5;
  logic [NREG-1:0] q;
  logic [NREG-1:0] chain;

  lcell_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb cfg_d = cfg_we ? cfg_t'(cfg_data) : cfg_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cfg_q <= '0;
    else             cfg_q <= cfg_d;
  end

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_we |=> $stable(cfg_q));

  lcell_lut u_lut (
    .tbl   (cfg_q.lut_tbl),
    .a_in  (a_in),
    .b_in  (b_in),
    .f5_op (cfg_q.f5_op),
    .f     (f),
    .f5    (f5)
  );

  assign chain = {q[NREG-2:0], wd_in[0]};

  for (genvar k = 0; k < NREG; k++) begin : g_elem
    lcell_store u_store (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .gsr       (gsr),
      .ce        (clk_en),
      .lsr       (lsr),
      .sr_first  (cfg_q.sr_first),
      .sr_val    (cfg_q.sr_val[k]),
      .is_latch  (cfg_q.is_latch[k]),
      .src       (cfg_q.reg_src[k]),
      .lut_bit   (f[k]),
      .wd_bit    (wd_in[k]),
      .chain_bit (chain[k]),
      .q         (q[k])
    );
    assign y_out[k] = cfg_q.out_reg[k] ? q[k] : f[k];
  end

  assign y_out[BUS_W-1] = f5;
endmodule

// File: tb/lut_cell_bench.sv
module lut_cell_bench;
  import lcell_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n, cfg_we, clk_en, lsr, gsr;
  logic [CFG_W-1:0] cfg_data;
  logic [4:0]       a_in, b_in, y_out;
  logic [3:0]       wd_in;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lut_cell u_lut_cell (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .a_in(a_in), .b_in(b_in), .wd_in(wd_in), .clk_en(clk_en), .lsr(lsr), .gsr(gsr),
    .y_out(y_out));

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic load_cfg(input cfg_t c);
    cfg_data = c; cfg_we = 1'b1; step(); cfg_we = 1'b0;
  endtask

  task automatic pulse_gsr();
    gsr = 1'b1; step(); gsr = 1'b0; #1;
  endtask

  function automatic logic tbl_bit(input cfg_t c, input int k, input logic [4:0] a, input logic [4:0] b);
    logic [3:0] ix;
    case (k)
      3: ix = a[4:1];
      2: ix = a[3:0];
      1: ix = b[4:1];
      default: ix = b[3:0];
    endcase
    return c.lut_tbl[k][ix];
  endfunction

  function automatic logic f5_model(input cfg_t c, input logic [4:0] a, input logic [4:0] b);
    logic t3, t0;
    t3 = tbl_bit(c, 3, a, b);
    t0 = tbl_bit(c, 0, a, b);
    case (c.f5_op)
      F5_NAND: return ~(t3 & t0);
      F5_XOR:  return t3 ^ t0;
      F5_MUX:  return a[4] ? t3 : t0;
      default: return ~(t3 ^ t0);
    endcase
  endfunction

  function automatic cfg_t base_cfg();
    cfg_t c = '0;
    c.lut_tbl[3] = 16'h8001;
    c.lut_tbl[2] = 16'h0F0F;
    c.lut_tbl[1] = 16'hAAAA;
    c.lut_tbl[0] = 16'hFF00;
    return c;
  endfunction

  task automatic t_reset();
    chk("R1 reset output", y_out, 5'b10000);
  endtask

  task automatic t_cfg_write();
    cfg_t c = base_cfg();
    cfg_t other = '0;
    a_in = 5'h1F; b_in = 5'h00;
    load_cfg(c);
    chk("R2 config loaded", y_out, {f5_model(c, a_in, b_in), tbl_bit(c,3,a_in,b_in),
        tbl_bit(c,2,a_in,b_in), tbl_bit(c,1,a_in,b_in), tbl_bit(c,0,a_in,b_in)});
    other.lut_tbl[3] = 16'h0000; other.f5_op = F5_XOR;
    cfg_data = other; cfg_we = 1'b0; step(); step();
    chk("R2 no write without enable", y_out, {f5_model(c, a_in, b_in), tbl_bit(c,3,a_in,b_in),
        tbl_bit(c,2,a_in,b_in), tbl_bit(c,1,a_in,b_in), tbl_bit(c,0,a_in,b_in)});
  endtask

  task automatic t_lut_map();
    cfg_t c = base_cfg();
    logic [4:0] av [4] = '{5'h1F, 5'h00, 5'h0A, 5'h1E};
    logic [4:0] bv [4] = '{5'h00, 5'h1F, 5'h15, 5'h01};
    load_cfg(c);
    for (int i = 0; i < 4; i++) begin
      a_in = av[i]; b_in = bv[i]; #1;
      chk("R3 table index mapping", {1'b0, y_out[3:0]}, {1'b0, tbl_bit(c,3,a_in,b_in),
          tbl_bit(c,2,a_in,b_in), tbl_bit(c,1,a_in,b_in), tbl_bit(c,0,a_in,b_in)});
    end
  endtask

  task automatic t_f5();
    cfg_t c = base_cfg();
    logic [4:0] av [3] = '{5'h1F, 5'h01, 5'h10};
    logic [4:0] bv [3] = '{5'h08, 5'h00, 5'h1F};
    for (int op = 0; op < 4; op++) begin
      c.f5_op = f5_e'(op);
      load_cfg(c);
      for (int i = 0; i < 3; i++) begin
        a_in = av[i]; b_in = bv[i]; #1;
        chk("R4 fifth output gate", {4'b0, y_out[4]}, {4'b0, f5_model(c, a_in, b_in)});
      end
    end
  endtask

  task automatic t_sources();
    cfg_t c = base_cfg();
    logic [3:0] qexp;
    logic       sbit [4] = '{1'b1, 1'b0, 1'b1, 1'b1};
    c.out_reg = 4'hF; c.f5_op = F5_XOR;
    c.reg_src[3] = SRC_LUT; c.reg_src[2] = SRC_WD; c.reg_src[1] = SRC_WD; c.reg_src[0] = SRC_LUT;
    clk_en = 1'b0; load_cfg(c);
    clk_en = 1'b1; a_in = 5'h1F; b_in = 5'h08; wd_in = 4'b0110;
    qexp = {tbl_bit(c,3,a_in,b_in), wd_in[2], wd_in[1], tbl_bit(c,0,a_in,b_in)};
    step();
    chk("R5 table and direct sources", {1'b0, y_out[3:0]}, {1'b0, qexp});
    for (int k = 0; k < 4; k++) c.reg_src[k] = SRC_SHIFT;
    c.sr_val = 4'h0;
    clk_en = 1'b0; load_cfg(c); pulse_gsr();
    qexp = 4'h0; clk_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      wd_in = {3'b000, sbit[i]}; a_in = 5'(i * 7); b_in = 5'(i * 5);
      qexp = {qexp[2:0], sbit[i]};
      step();
      chk("R5 shift chain with live decode", y_out, {f5_model(c, a_in, b_in), qexp});
    end
    clk_en = 1'b0;
  endtask

  task automatic t_ce_hold();
    cfg_t c = base_cfg();
    c.out_reg = 4'hF;
    for (int k = 0; k < 4; k++) c.reg_src[k] = SRC_WD;
    clk_en = 1'b0; load_cfg(c);
    clk_en = 1'b1; wd_in = 4'b1001; step();
    clk_en = 1'b0; wd_in = 4'b0110; step(); step();
    chk("R6 hold with enable low", {1'b0, y_out[3:0]}, 5'b01001);
  endtask

  task automatic t_sr_priority();
    cfg_t c = base_cfg();
    c.out_reg = 4'hF; c.sr_val = 4'b1010; c.sr_first = 1'b1;
    for (int k = 0; k < 4; k++) c.reg_src[k] = SRC_WD;
    clk_en = 1'b0; load_cfg(c);
    clk_en = 1'b1; wd_in = 4'b0101; step(); clk_en = 1'b0;
    lsr = 1'b1; step(); lsr = 1'b0;
    chk("R7 set/reset first ignores enable", {1'b0, y_out[3:0]}, 5'b01010);
    c.sr_first = 1'b0; load_cfg(c);
    clk_en = 1'b1; wd_in = 4'b0101; step(); clk_en = 1'b0;
    lsr = 1'b1; step();
    chk("R7 enable first blocks set/reset", {1'b0, y_out[3:0]}, 5'b00101);
    clk_en = 1'b1; step(); lsr = 1'b0; clk_en = 1'b0;
    chk("R7 set/reset with enable", {1'b0, y_out[3:0]}, 5'b01010);
  endtask

  task automatic t_gsr();
    cfg_t c = base_cfg();
    c.out_reg = 4'hF; c.sr_val = 4'b0110;
    for (int k = 0; k < 4; k++) c.reg_src[k] = SRC_WD;
    clk_en = 1'b0; load_cfg(c);
    clk_en = 1'b1; wd_in = 4'b1001; step();
    chk("R8 before global set/reset", {1'b0, y_out[3:0]}, 5'b01001);
    gsr = 1'b1; #1;
    chk("R8 asynchronous force", {1'b0, y_out[3:0]}, 5'b00110);
    wd_in = 4'b1111; lsr = 1'b1; step(); lsr = 1'b0;
    chk("R8 override across edge", {1'b0, y_out[3:0]}, 5'b00110);
    gsr = 1'b0; clk_en = 1'b0; #1;
  endtask

  task automatic t_latch();
    cfg_t c = base_cfg();
    c.out_reg = 4'hF; c.is_latch = 4'hF; c.sr_val = 4'h0;
    for (int k = 0; k < 4; k++) c.reg_src[k] = SRC_WD;
    clk_en = 1'b0; load_cfg(c); pulse_gsr();
    @(posedge clk); #1;
    clk_en = 1'b1; wd_in = 4'b0011; #1;
    chk("R9 latch transparent while clock high", {1'b0, y_out[3:0]}, 5'b00011);
    @(negedge clk); #1; wd_in = 4'b1100; #1;
    chk("R9 latch holds while clock low", {1'b0, y_out[3:0]}, 5'b00011);
    @(posedge clk); #1;
    chk("R9 latch opens on clock high", {1'b0, y_out[3:0]}, 5'b01100);
    clk_en = 1'b0; wd_in = 4'b0000; #1;
    chk("R9 latch holds with enable low", {1'b0, y_out[3:0]}, 5'b01100);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_data = '0; clk_en = 1'b0; lsr = 1'b0; gsr = 1'b1;
    a_in = '0; b_in = '0; wd_in = '0;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1; gsr = 1'b0;
    repeat (3) step();
    t_reset();
    t_cfg_write();
    t_lut_map();
    t_f5();
    t_sources();
    t_ce_hold();
    t_sr_priority();
    t_gsr();
    t_latch();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule